// File: doc/BRIEF.md
# Automatic Reference Selection Controller

This controller decides how a timing PLL is operated and which of two external timing references it follows. It reports an operating state (freerun, normal or holdover) and the index of the physical reference input the PLL should track. Loss detection and the PLL itself sit outside the block. The block only reacts to two loss indicators. The first indicator reports the reference in the primary role and the second reports the reference in the secondary role.

Two mode bits pick the operating style. In manual mode the mode bits and a select bit drive the outputs directly. In automatic mode an event-driven state machine walks five states, driven by the synchronized loss indicators. Losing the primary-role reference leads to holdover first. The controller falls back to the secondary-role reference only after a guard interval that a cycle counter measures. The select bit then swaps which physical input plays the primary role.

Top module: `refsel_top`

## Requirements
- R1: While rstN is low and in the first cycle after it rises, opState is 0 (freerun) and refIdx is 0. The automatic state is freerun with the primary role.
- R2: With modeSel 2'b00 the next cycle shows normal, and with 2'b01 it shows holdover. In both cases refIdx equals swapSel. With modeSel 2'b10 the next cycle shows freerun with refIdx 0.
- R3: modeSel 2'b11 selects automatic mode. In that mode refIdx is the active role (0 primary, 1 secondary) XOR swapSel, so swapSel=1 routes the primary role to physical input 1.
- R4: Each loss input passes through a two-flop synchronizer. A change applied before clock edge k therefore first affects the state at edge k+2 and is first seen on the outputs after that edge.
- R5: In automatic mode, a synchronized loss pair {primary,secondary} of 2'b00 or 2'b01 moves every state to normal on the primary role in one cycle.
- R6: In automatic mode, pair 2'b10 in normal-primary moves to holdover with the primary as last reference in one cycle, and the guard counter starts from zero.
- R7: Holdover-primary under a steady pair 2'b10 lasts guardLimit+1 cycles and then becomes normal on the secondary role. The counter restarts from zero whenever the pair leaves 2'b10, so a shorter loss never causes a fallback.
- R8: In automatic mode, pair 2'b10 moves freerun and holdover-secondary straight to normal on the secondary role. Normal-secondary holds.
- R9: In automatic mode, pair 2'b11 moves normal-primary to holdover-primary and normal-secondary to holdover-secondary. Freerun and both holdover states hold.
- R10: opState encodes 0 freerun, 1 normal, 2 holdover. The value 3 never appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | 00 manual normal, 01 manual holdover, 10 manual freerun, 11 automatic |
| swapSel | input | 1 | Manual: input to use. Automatic: swaps primary and secondary roles |
| lossPri | input | 1 | Loss of the primary-role reference (asynchronous) |
| lossSec | input | 1 | Loss of the secondary-role reference (asynchronous) |
| guardLimit | input | GUARD_W | Guard interval terminal count, in cycles |
| refIdx | output | 1 | Physical reference input to follow |
| opState | output | 2 | Operating state: 0 freerun, 1 normal, 2 holdover |

## Verification
The bench targets the guard interval edges. It measures the holdover length against guardLimit+1 and also runs with a limit of zero. If the counter were off by one, or never cleared, the holdover would be too long or too short. A design that did not clear the counter would fall back to the secondary reference after a short loss or after an interruption by a double loss. The bench also enters automatic mode from manual freerun while the primary reference is already lost, which must go straight to secondary. It uses swapSel in automatic mode, where a missing XOR would point the PLL at the wrong physical input. Because the loss inputs are delayed through the synchronizer, a design with the wrong number of stages reacts a cycle early or late, and the per-cycle comparison catches this.

// File: rtl/refsel_pkg.sv
package refsel_pkg;

  typedef enum logic [1:0] {
    KIND_FREE = 2'd0,
    KIND_NORM = 2'd1,
    KIND_HOLD = 2'd2
  } opKindT;

  typedef struct packed {
    opKindT kind;
    logic   role;   // 0 primary role, 1 secondary role
  } selStateT;

  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } guardCtlT;

  localparam logic [1:0] MODE_MAN_NORM = 2'b00;
  localparam logic [1:0] MODE_MAN_HOLD = 2'b01;
  localparam logic [1:0] MODE_MAN_FREE = 2'b10;
  localparam logic [1:0] MODE_AUTO     = 2'b11;

endpackage

// File: rtl/refsel_datapath.sv
module refsel_datapath
  import refsel_pkg::*;
#(
  parameter int GUARD_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               lossPri,
  input  logic               lossSec,
  input  logic [GUARD_W-1:0] guardLimit,
  input  logic [1:0]         modeSel,
  input  logic               swapSel,
  input  guardCtlT           guardCtl,
  input  selStateT           stateQ,
  output logic [1:0]         syncPair,
  output logic               guardDone,
  output logic               refIdx,
  output logic [1:0]         opState
);

  localparam int NUM_LOSS = 2;

  logic [NUM_LOSS-1:0] lossRaw;
  logic [GUARD_W-1:0]  guardCnt;
  logic                flipQ;

  assign lossRaw = {lossPri, lossSec};

  // one synchronizer chain per loss indicator
  for (genvar g = 0; g < NUM_LOSS; g++) begin : gSync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[SYNC_STAGES-2:0], lossRaw[g]};
    end
    assign syncPair[g] = chain[SYNC_STAGES-1];
  end

  // guard interval counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                guardCnt <= '0;
    else if (guardCtl.cntClear) guardCnt <= '0;
    else if (guardCtl.cntRun)   guardCnt <= guardCnt + 1'b1;
  end

  assign guardDone = (guardCnt == guardLimit);

  // role swap applies only in automatic mode
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flipQ <= 1'b0;
    else       flipQ <= (modeSel == MODE_AUTO) && swapSel;
  end

  assign opState = stateQ.kind;
  assign refIdx  = stateQ.role ^ flipQ;

endmodule

// File: rtl/refsel_control.sv
module refsel_control
  import refsel_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeSel,
  input  logic       swapSel,
  input  logic [1:0] syncPair,
  input  logic       guardDone,
  output guardCtlT   guardCtl,
  output selStateT   stateQ
);

  selStateT stateNxt;
  logic     isAuto;
  logic     inGuard;

  assign isAuto  = (modeSel == MODE_AUTO);
  assign inGuard = isAuto && (stateQ.kind == KIND_HOLD) && !stateQ.role
                   && (syncPair == 2'b10);

  assign guardCtl.cntClear = !inGuard;
  assign guardCtl.cntRun   = inGuard && !guardDone;

  always_comb begin
    stateNxt = stateQ;
    if (!isAuto) begin
      case (modeSel)
        MODE_MAN_NORM: stateNxt = '{kind: KIND_NORM, role: swapSel};
        MODE_MAN_HOLD: stateNxt = '{kind: KIND_HOLD, role: swapSel};
        default:       stateNxt = '{kind: KIND_FREE, role: 1'b0};
      endcase
    end else begin
      case (syncPair)
        2'b10: begin
          case (stateQ.kind)
            KIND_FREE: stateNxt = '{kind: KIND_NORM, role: 1'b1};
            KIND_NORM: if (!stateQ.role) stateNxt = '{kind: KIND_HOLD, role: 1'b0};
            KIND_HOLD: if (stateQ.role || guardDone)
                         stateNxt = '{kind: KIND_NORM, role: 1'b1};
            default:   stateNxt = '{kind: KIND_FREE, role: 1'b0};
          endcase
        end
        2'b11: begin
          if (stateQ.kind == KIND_NORM)
            stateNxt = '{kind: KIND_HOLD, role: stateQ.role};
        end
        default: stateNxt = '{kind: KIND_NORM, role: 1'b0};
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= '{kind: KIND_FREE, role: 1'b0};
    else       stateQ <= stateNxt;
  end

endmodule

// File: rtl/refsel_top.sv
module refsel_top
  import refsel_pkg::*;
#(
  parameter int GUARD_W = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         modeSel,
  input  logic               swapSel,
  input  logic               lossPri,
  input  logic               lossSec,
  input  logic [GUARD_W-1:0] guardLimit,
  output logic               refIdx,
  output logic [1:0]         opState
);

  guardCtlT   guardCtl;
  selStateT   stateQ;
  logic [1:0] syncPair;
  logic       guardDone;

  refsel_control control_i (
    .clk       (clk),
    .rstN      (rstN),
    .modeSel   (modeSel),
    .swapSel   (swapSel),
    .syncPair  (syncPair),
    .guardDone (guardDone),
    .guardCtl  (guardCtl),
    .stateQ    (stateQ)
  );

  refsel_datapath #(.GUARD_W(GUARD_W), .SYNC_STAGES(2)) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .lossPri    (lossPri),
    .lossSec    (lossSec),
    .guardLimit (guardLimit),
    .modeSel    (modeSel),
    .swapSel    (swapSel),
    .guardCtl   (guardCtl),
    .stateQ     (stateQ),
    .syncPair   (syncPair),
    .guardDone  (guardDone),
    .refIdx     (refIdx),
    .opState    (opState)
  );

endmodule

// File: rtl/refsel_checker.sv
module refsel_checker
  import refsel_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [1:0] modeSel,
  input logic       swapSel,
  input logic [1:0] syncPair,
  input selStateT   stateQ,
  input logic       guardDone,
  input logic       refIdx,
  input logic [1:0] opState
);

  a_r10_state_legal: assert property (@(posedge clk) disable iff (!rstN)
    opState != 2'd3);

  a_r2_manual_free: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_MAN_FREE) |=> (opState == KIND_FREE && refIdx == 1'b0));

  a_r5_clear_to_normal: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_AUTO && !syncPair[1]) |=>
      (stateQ.kind == KIND_NORM && !stateQ.role));

  a_r9_both_lost: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_AUTO && syncPair == 2'b11 && stateQ.kind == KIND_NORM) |=>
      (stateQ.kind == KIND_HOLD && stateQ.role == $past(stateQ.role)));

  a_r7_guard_gate: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_AUTO && stateQ.kind == KIND_HOLD && !stateQ.role &&
     !guardDone && syncPair == 2'b10) |=> (stateQ.kind == KIND_HOLD));

  a_r3_swap_map: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == MODE_AUTO) |=> (refIdx == (stateQ.role ^ $past(swapSel))));

endmodule

bind refsel_top refsel_checker chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .swapSel   (swapSel),
  .syncPair  (syncPair),
  .stateQ    (stateQ),
  .guardDone (guardDone),
  .refIdx    (refIdx),
  .opState   (opState)
);

// File: tb/refsel_top_tb.sv
module refsel_top_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int GW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [1:0]    modeSel = 2'b10;
  logic          swapSel = 1'b0;
  logic          lossPri = 1'b0;
  logic          lossSec = 1'b0;
  logic [GW-1:0] guardLimit = 16'd5;
  logic          refIdx;
  logic [1:0]    opState;

  int    nRun = 0;
  int    nFail = 0;
  int    cycles = 0;
  string curReq = "R1";

  // behavioural model state
  int mKind = 0, mRole = 0, mFlip = 0, mCnt = 0;
  int sA[2], sB[2];
  int holdRun = 0, lastRun = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  refsel_top #(.GUARD_W(GW)) dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .swapSel(swapSel),
    .lossPri(lossPri), .lossSec(lossSec), .guardLimit(guardLimit),
    .refIdx(refIdx), .opState(opState)
  );

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mKind = 0; mRole = 0; mFlip = 0; mCnt = 0;
      sA = '{0, 0}; sB = '{0, 0};
    end else begin
      int pri, sec, nk, nr;
      bit done, guarding;
      pri = sB[0]; sec = sB[1];
      done = (mCnt == int'(guardLimit));
      nk = mKind; nr = mRole;
      if (modeSel == 2'b00) begin nk = 1; nr = swapSel; end
      else if (modeSel == 2'b01) begin nk = 2; nr = swapSel; end
      else if (modeSel == 2'b10) begin nk = 0; nr = 0; end
      else if (pri == 0) begin nk = 1; nr = 0; end
      else if (sec == 0) begin
        if (mKind == 0) begin nk = 1; nr = 1; end
        else if (mKind == 1 && mRole == 0) begin nk = 2; nr = 0; end
        else if (mKind == 2 && (mRole == 1 || done)) begin nk = 1; nr = 1; end
      end else if (mKind == 1) begin nk = 2; end
      guarding = (modeSel == 2'b11) && mKind == 2 && mRole == 0 && pri == 1 && sec == 0;
      if (!guarding) mCnt = 0;
      else if (!done) mCnt = mCnt + 1;
      mKind = nk; mRole = nr;
      mFlip = (modeSel == 2'b11 && swapSel) ? 1 : 0;
      sB = sA;
      sA = '{int'(lossPri), int'(lossSec)};
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    cycles++;
    nRun++;
    if (opState !== 2'(mKind) || refIdx !== 1'(mRole ^ mFlip)) begin
      nFail++;
      $display("FAIL %s: opState=%0d refIdx=%0d expected opState=%0d refIdx=%0d",
               curReq, opState, refIdx, mKind, mRole ^ mFlip);
    end
    if (opState == 2'd2) holdRun++;
    else begin
      if (holdRun != 0) lastRun = holdRun;
      holdRun = 0;
    end
    if (cycles > 100000) begin
      nFail++;
      $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  task automatic drive(input logic [1:0] m, input logic s, input logic lp,
                       input logic ls, input int n);
    @(posedge clk); #2;
    modeSel = m; swapSel = s; lossPri = lp; lossSec = ls;
    repeat (n) @(posedge clk);
  endtask

  task automatic checkVal(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    checkVal("R1", int'(opState), 0);
    checkVal("R1", int'(refIdx), 0);
    @(posedge clk); #2; rstN = 1'b1;
    @(negedge clk);
    checkVal("R1", int'(opState), 0);

    // R2 manual modes
    curReq = "R2";
    drive(2'b00, 0, 0, 0, 4);
    drive(2'b00, 1, 0, 0, 4);
    drive(2'b01, 1, 0, 0, 4);
    drive(2'b10, 1, 0, 0, 4);
    drive(2'b01, 0, 0, 0, 4);

    // R8 freerun with primary already lost goes straight to secondary
    curReq = "R8";
    drive(2'b10, 0, 1, 0, 5);
    drive(2'b11, 0, 1, 0, 4);
    // R9 both lost from normal-secondary
    curReq = "R9";
    drive(2'b11, 0, 1, 1, 6);
    curReq = "R8";
    drive(2'b11, 0, 1, 0, 6);
    // R5 clear
    curReq = "R5";
    drive(2'b11, 0, 0, 0, 5);
    drive(2'b11, 0, 0, 1, 5);
    // R9 from normal-primary, no timer under double loss
    curReq = "R9";
    drive(2'b11, 0, 1, 1, 12);
    curReq = "R5";
    drive(2'b11, 0, 0, 0, 6);

    // R6 / R7 guard interval
    curReq = "R7";
    drive(2'b11, 0, 1, 0, 16);
    @(negedge clk);
    checkVal("R7", lastRun, int'(guardLimit) + 1);
    checkVal("R7", int'(refIdx), 1);
    curReq = "R4";
    drive(2'b11, 0, 0, 0, 1);
    @(negedge clk);
    checkVal("R4", int'(opState), 1);   // synchronizer delay: still normal
    checkVal("R4", int'(refIdx), 1);
    repeat (5) @(posedge clk);
    curReq = "R6";
    drive(2'b11, 0, 1, 0, 3);
    curReq = "R7";
    drive(2'b11, 0, 0, 0, 6);
    drive(2'b11, 0, 1, 0, 4);
    drive(2'b11, 0, 1, 1, 3);
    drive(2'b11, 0, 1, 0, 20);

    // R3 swapped roles
    curReq = "R3";
    drive(2'b11, 1, 0, 0, 6);
    drive(2'b11, 1, 1, 0, 14);
    drive(2'b11, 1, 0, 0, 6);
    drive(2'b10, 1, 0, 0, 3);
    drive(2'b11, 1, 0, 0, 3);

    // R7 zero guard limit
    curReq = "R7";
    @(posedge clk); #2; guardLimit = '0;
    drive(2'b11, 0, 0, 0, 6);
    drive(2'b11, 0, 1, 0, 8);
    @(negedge clk);
    checkVal("R7", lastRun, 1);
    curReq = "R10";
    drive(2'b11, 0, 0, 0, 4);
    checkVal("R10", int'(opState != 2'd3), 1);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule